// File: doc/BRIEF.md
# Pipelined SAR ADC Read Sequencer

This block runs an 8-bit successive-approximation conversion engine in step with serial-bus read transfers. Once a read transfer has been addressed, every acknowledge clock that ends starts one conversion. The block drives a trial code to an external DAC, reads back one comparator bit per step, and builds the result from the most significant bit down. The finished code goes into a transmit register, where the bus shifter picks it up.

The conversion is pipelined against the bus. A conversion runs while the byte before it is shifted out, so each byte read carries the sample taken at the acknowledge one byte earlier. The first byte of a read therefore returns whatever the register already held. The block holds a channel pointer over four inputs. The pointer can advance after each conversion and wraps from the last channel to the first. In differential mode the result is given as two's complement instead of straight binary.

Top module: `sar_read_seq`

## Requirements
- R1: After reset, `tx_byte` is 00h, `chan_sel` is 0, `busy` is 0 and `trial_code` is 00h.
- R2: An `ack_end` pulse that comes before any `rd_start` since reset starts no conversion: `busy` stays 0 and `tx_byte` keeps its value.
- R3: A `rd_start` pulse while idle loads `chan_sel` from `chan_init` and arms the sequencer for the read.
- R4: An `ack_end` pulse while armed and idle starts a conversion. `busy` is high from the next cycle for exactly 8 cycles, and the first trial code is 80h.
- R5: Trial codes run MSB first. In each step the trial is the bits already kept, OR-ed with the bit under test. A bit is kept when `cmp_in` is 1 (input at or above the trial level). `trial_code` is 00h while idle.
- R6: The result goes into `tx_byte` in the cycle `busy` falls. It stays unchanged for the whole of the next conversion, so a byte read during conversion N carries result N-1.
- R7: With `auto_inc` = 1 (sampled when a conversion starts), `chan_sel` advances by one when that conversion finishes, with 3 wrapping to 0. With `auto_inc` = 0 it does not change. During a conversion `chan_sel` holds the channel being converted.
- R8: With `diff_mode` = 0 (sampled at start) the result is straight binary. With `diff_mode` = 1 it is two's complement, formed by inverting bit 7 of the binary code.
- R9: An `ack_end` pulse while `busy` is high is ignored. The running conversion keeps its timing and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_start | input | 1 | Pulse: a valid read address was received |
| ack_end | input | 1 | Pulse: trailing edge of an acknowledge clock |
| chan_init | input | 2 | Channel loaded at read start |
| auto_inc | input | 1 | Advance the channel after each conversion |
| diff_mode | input | 1 | 1 = differential (two's complement result) |
| cmp_in | input | 1 | Comparator: input at or above trial level |
| trial_code | output | 8 | Trial code to the DAC |
| chan_sel | output | 2 | Selected input channel |
| tx_byte | output | 8 | Data register for transmission |
| busy | output | 1 | Conversion in progress |

## Verification
A step counter that is off by one shows up at once as a wrong `trial_code` on the first step, and as `busy` falling one cycle early or late. A wrong kept bit gives a wrong `tx_byte` in the cycle `busy` falls. A data register written at the wrong time breaks the one-byte lag, and the next byte read returns the wrong sample. A pointer fault shows in `chan_sel` right after a conversion finishes, and a lost format bit shows as bit 7 of the next result.

// File: rtl/sar_seq_pkg.sv
// Package: shared types for the pipelined SAR read sequencer.
// Assumes: nothing; holds only type definitions.
package sar_seq_pkg;

    // Output coding of a finished conversion.
    typedef enum logic {
        CODE_BINARY = 1'b0,
        CODE_TWOS   = 1'b1
    } code_fmt_e;

    // Settings captured when a conversion starts.
    typedef struct packed {
        code_fmt_e fmt;
        logic      step_chan;
    } conv_cfg_t;

endpackage

// File: rtl/sar_engine.sv
// Module: sar_engine
// Successive-approximation core. A start pulse while idle begins W steps,
// MSB first. Each step shows the kept bits plus the bit under test on
// trial, and keeps that bit when cmp_in is 1. done is high during the last
// step, and result then carries the final code.
// Assumes: cmp_in settles within one clock of trial changing.
module sar_engine #(
    parameter int W = 8,
    localparam int SW = (W > 1) ? $clog2(W) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_in,
    output logic [W-1:0] trial,
    output logic [W-1:0] result,
    output logic         busy,
    output logic         done
);

    logic [W-1:0]  acc_q;
    logic [SW-1:0] step_q;
    logic          busy_q;
    logic [W-1:0]  test_bit;
    logic [W-1:0]  keep;

    // One-hot mask of the bit under test in the current step.
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign test_bit[i] = busy_q && (step_q == SW'(i));
    end

    // Trial code, and the accumulator with the bit kept if cmp_in says so.
    always_comb begin
        trial = acc_q | test_bit;
        keep  = cmp_in ? trial : acc_q;
    end

    assign busy   = busy_q;
    assign done   = busy_q && (step_q == '0);
    assign result = keep;

    // Step sequencing and bit accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (start) begin
                acc_q  <= '0;
                step_q <= SW'(W - 1);
                busy_q <= 1'b1;
            end
        end else if (step_q == '0) begin
            acc_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            acc_q  <= keep;
            step_q <= step_q - 1'b1;
        end
    end

endmodule

// File: rtl/chan_pointer.sv
// Module: chan_pointer
// Input channel pointer. load writes load_val; advance steps it by one and
// wraps after the last channel. load takes priority.
// Assumes: load_val < NCH.
module chan_pointer #(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          advance,
    output logic [CW-1:0] ptr
);

    logic [CW-1:0] ptr_q;
    logic [CW-1:0] ptr_inc;

    // Next channel in round-robin order.
    always_comb begin
        if (ptr_q == CW'(NCH - 1)) ptr_inc = '0;
        else                       ptr_inc = ptr_q + 1'b1;
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (load)    ptr_q <= load_val;
        else if (advance) ptr_q <= ptr_inc;
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/result_reg.sv
// Module: result_reg
// Data register for transmission. On capture it stores the code in the
// requested format (binary, or two's complement by MSB inversion) and holds
// it until the next capture.
// Assumes: din is a straight binary code.
module result_reg
    import sar_seq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  code_fmt_e    fmt,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] coded;
    logic [W-1:0] dout_q;

    // Format conversion; the single-bit case just inverts that bit.
    if (W > 1) begin : g_wide
        always_comb begin
            coded = din;
            if (fmt == CODE_TWOS) coded = {~din[W-1], din[W-2:0]};
        end
    end else begin : g_narrow
        always_comb begin
            coded = (fmt == CODE_TWOS) ? ~din : din;
        end
    end

    // Holding register for the transmit byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout_q <= '0;
        else if (capture) dout_q <= coded;
    end

    assign dout = dout_q;

endmodule

// File: rtl/sar_read_seq.sv
// Module: sar_read_seq (top)
// Ties SAR conversions to read transfers. rd_start arms the sequencer and
// loads the channel. Each ack_end while armed and idle starts a conversion
// of the current channel, with format and auto-increment captured at the
// start. The result lands in tx_byte at the end, so the byte shifted out
// during a conversion is the previous result.
// Assumes: rd_start and ack_end are single-cycle pulses, and acknowledge
// edges are at least DATA_W + 1 cycles apart in normal use.
module sar_read_seq
    import sar_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 4,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic              ack_end,
    input  logic [CH_W-1:0]   chan_init,
    input  logic              auto_inc,
    input  logic              diff_mode,
    input  logic              cmp_in,
    output logic [DATA_W-1:0] trial_code,
    output logic [CH_W-1:0]   chan_sel,
    output logic [DATA_W-1:0] tx_byte,
    output logic              busy
);

    logic              armed_q;
    conv_cfg_t         cfg_q;
    logic              conv_go;
    logic              eng_busy;
    logic              eng_done;
    logic [DATA_W-1:0] eng_result;

    // Start condition: armed, idle, and no read start in the same cycle.
    assign conv_go = ack_end && armed_q && !eng_busy && !rd_start;

    // Arm flag: set by a read start taken while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                     armed_q <= 1'b0;
        else if (rd_start && !eng_busy) armed_q <= 1'b1;
    end

    // Capture this conversion's format and step setting at its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{fmt: CODE_BINARY, step_chan: 1'b0};
        end else if (conv_go) begin
            cfg_q.fmt       <= diff_mode ? CODE_TWOS : CODE_BINARY;
            cfg_q.step_chan <= auto_inc;
        end
    end

    sar_engine #(.W(DATA_W)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (conv_go),
        .cmp_in (cmp_in),
        .trial  (trial_code),
        .result (eng_result),
        .busy   (eng_busy),
        .done   (eng_done)
    );

    chan_pointer #(.NCH(NUM_CH)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rd_start && !eng_busy),
        .load_val (chan_init),
        .advance  (eng_done && cfg_q.step_chan),
        .ptr      (chan_sel)
    );

    result_reg #(.W(DATA_W)) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (eng_done),
        .fmt     (cfg_q.fmt),
        .din     (eng_result),
        .dout    (tx_byte)
    );

    assign busy = eng_busy;

endmodule

// File: rtl/sar_read_seq_chk.sv
// Module: sar_read_seq_chk
// Property checker bound to sar_read_seq. Watches only the ports.
// Assumes: synchronous active-low reset on rst_n.
module sar_read_seq_chk #(
    parameter int DATA_W = 8,
    parameter int CH_W   = 2,
    localparam int CNT_W = $clog2(DATA_W + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] trial_code,
    input logic [CH_W-1:0]   chan_sel,
    input logic [DATA_W-1:0] tx_byte,
    input logic              busy
);

    logic [CNT_W-1:0] busy_len;

    // Length of the current busy run, counted in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    // R4: the first trial of a conversion tests the MSB alone.
    assert_first_trial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> trial_code == {1'b1, {(DATA_W-1){1'b0}}});

    // R4: a conversion lasts exactly DATA_W cycles.
    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == CNT_W'(DATA_W));

    // R5: no trial code is driven while idle.
    assert_idle_trial_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> trial_code == '0);

    // R6: the transmit byte holds while a conversion runs.
    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tx_byte));

    // R7: the channel is fixed during a conversion.
    assert_chan_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(chan_sel));

endmodule

bind sar_read_seq sar_read_seq_chk #(.DATA_W(DATA_W), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trial_code (trial_code),
    .chan_sel   (chan_sel),
    .tx_byte    (tx_byte),
    .busy       (busy)
);

// File: tb/tb_sar_read_seq.sv
// Bench for sar_read_seq. An ideal comparator model answers the trial codes.
// The driver pushes each expected result into a queue, and the monitor pops
// one per byte read while the next conversion runs.
module tb_sar_read_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_start = 1'b0;
    logic       ack_end = 1'b0;
    logic [1:0] chan_init = 2'd0;
    logic       auto_inc = 1'b0;
    logic       diff_mode = 1'b0;
    logic       cmp_in;
    logic [7:0] trial_code;
    logic [1:0] chan_sel;
    logic [7:0] tx_byte;
    logic       busy;

    logic [7:0] ana [4];
    logic [7:0] exp_q [$];
    int         n_chk = 0;
    int         n_bad = 0;
    logic [1:0] chan_m = 2'd0;
    event       mon_ev;

    always #4 clk = ~clk;

    // Ideal comparator: input at or above the trial level.
    assign cmp_in = (ana[chan_sel] >= trial_code);

    sar_read_seq dut (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .ack_end(ack_end),
        .chan_init(chan_init), .auto_inc(auto_inc), .diff_mode(diff_mode),
        .cmp_in(cmp_in), .trial_code(trial_code), .chan_sel(chan_sel),
        .tx_byte(tx_byte), .busy(busy)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: each byte read pops the next expected value and compares it.
    always begin
        @(mon_ev);
        if (exp_q.size() == 0) begin
            chk(1'b0, "R6 queue empty", tx_byte, 0);
        end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(tx_byte == e, "R6 byte read carries previous result", tx_byte, e);
        end
    end

    // Driver: one acknowledge, a byte read during the conversion, checks per step.
    task automatic convert(input logic extra_ack);
        logic [7:0] acc;
        logic [7:0] res;
        logic [7:0] tr;
        res = diff_mode ? (ana[chan_m] ^ 8'h80) : ana[chan_m];
        exp_q.push_back(res);
        @(negedge clk); ack_end = 1'b1;
        @(negedge clk); ack_end = 1'b0;
        chk(busy == 1'b1, "R4 busy after ack", busy, 1);
        acc = 8'h00;
        for (int k = 7; k >= 0; k--) begin
            tr = acc | (8'h01 << k);
            chk(trial_code == tr, "R5 trial code step", trial_code, tr);
            chk(busy == 1'b1, "R4 busy during steps", busy, 1);
            chk(chan_sel == chan_m, "R7 channel held", chan_sel, chan_m);
            if (k == 3) -> mon_ev;
            if (extra_ack && k == 5) ack_end = 1'b1;
            if (k == 4) ack_end = 1'b0;
            if (ana[chan_m] >= tr) acc = tr;
            @(negedge clk);
        end
        if (auto_inc) chan_m = chan_m + 2'd1;
        chk(busy == 1'b0, "R4 busy ends after 8 cycles", busy, 0);
        chk(tx_byte == res, "R8 result format at end", tx_byte, res);
        chk(chan_sel == chan_m, "R7 channel after conversion", chan_sel, chan_m);
        repeat (2) @(negedge clk);
    endtask

    task automatic start_read(input logic [1:0] ch, input logic inc, input logic dif);
        @(negedge clk);
        chan_init = ch; auto_inc = inc; diff_mode = dif; rd_start = 1'b1;
        @(negedge clk); rd_start = 1'b0;
        chan_m = ch;
        chk(chan_sel == ch, "R3 channel loaded at read start", chan_sel, ch);
        chk(busy == 1'b0, "R3 no conversion on read start", busy, 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        ana[0] = 8'h00; ana[1] = 8'h80; ana[2] = 8'h5A; ana[3] = 8'hFF;
        exp_q.push_back(8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_byte == 8'h00, "R1 tx_byte reset", tx_byte, 0);
        chk(chan_sel == 2'd0, "R1 chan_sel reset", chan_sel, 0);
        chk(busy == 1'b0, "R1 busy reset", busy, 0);
        chk(trial_code == 8'h00, "R1 trial_code reset", trial_code, 0);

        // R2: acknowledge before any read start does nothing.
        ack_end = 1'b1; @(negedge clk); ack_end = 1'b0;
        chk(busy == 1'b0, "R2 no start without read", busy, 0);
        @(negedge clk);
        chk(tx_byte == 8'h00, "R2 tx unchanged", tx_byte, 0);

        // Auto-increment read, binary, wrapping 3 -> 0.
        start_read(2'd2, 1'b1, 1'b0);
        convert(1'b0);            // ch2
        convert(1'b0);            // ch3
        convert(1'b0);            // ch0 after wrap
        convert(1'b1);            // ch1, R9 extra ack while busy
        @(negedge clk);
        chk(busy == 1'b0, "R9 extra ack started nothing", busy, 0);

        // Fixed-channel read, differential.
        start_read(2'd1, 1'b0, 1'b1);
        convert(1'b0);            // ch1 0x80 -> 0x00
        ana[1] = 8'h10;
        convert(1'b0);            // ch1 0x10 -> 0x90
        ana[1] = 8'hFF;
        convert(1'b0);            // ch1 0xFF -> 0x7F
        -> mon_ev;                // last byte read
        @(negedge clk);
        chk(exp_q.size() == 0, "R6 all results read", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule